// File: doc/BRIEF.md
# Data-Space Address Generation Unit

This block forms the effective address of every load or store issued by an 8-bit datapath. It then steers the access to one of three regions of a 16-bit data space: the general register file, the I/O register window or the internal SRAM. One address is taken from the instruction word. The other is built from one of three 16-bit pointer pairs held in the general registers, using one of five modes. Two of those modes move the pointer as a side effect. The block returns the new pointer value and a write strobe, and the register file outside the block commits them.

A request is offered with `req_valid`. It is taken on a rising clock edge when `req_ready` is also high. `req_ready` falls only while an SRAM access is in its first cycle. During that cycle a request held on the inputs is not taken. The requester may keep `req_valid` high and keep its fields stable until `req_ready` returns, or it may withdraw the request. Nothing is queued. Results come out on plain outputs and cannot be stalled: `done` pulses for exactly one cycle. In that same cycle `oor`, `mode_err` and `wb_valid` are qualified. `req_ready` is high again in the `done` cycle, so back-to-back requests are accepted.

Top module: `dspace_agu`

## Requirements
- R1: An effective address in 0x0000..0x001F raises only `sel_rf`. At most one of `sel_rf`, `sel_io` and `sel_sram` is high at any time. The chosen select stays high from the cycle after acceptance through the `done` cycle.
- R2: An effective address in 0x0020..0x005F raises only `sel_io`. An address in 0x0060..0x00DF raises only `sel_sram`.
- R3: An effective address at 0x00E0 or above raises no region select. `oor` is high in the `done` cycle, and `done` comes one cycle after acceptance.
- R4: Mode 0 (direct) uses `direct_addr` as the effective address. It ignores `ptr_sel` and never raises `wb_valid`.
- R5: Mode 1 (indirect) uses the pointer chosen by `ptr_sel` as the effective address, and raises no write-back. `ptr_sel` 0 selects X (`ptr_x`), 1 selects Y (`ptr_y`) and 2 selects Z (`ptr_z`).
- R6: Mode 2 (displacement) with Y or Z gives the pointer plus the unsigned 6-bit `disp` (0..63), modulo 2^16. It raises no write-back.
- R7: Mode 3 (pre-decrement) gives the pointer minus one, modulo 2^16, as the effective address. In the `done` cycle it drives the same value on `wb_data`, raises `wb_valid`, and sets `wb_ptr` to the `ptr_sel` code. This happens even when the address is out of range.
- R8: Mode 4 (post-increment) gives the unchanged pointer as the effective address. In the `done` cycle it drives the pointer plus one, modulo 2^16, on `wb_data`, raises `wb_valid`, and sets `wb_ptr` to the `ptr_sel` code.
- R9: Three kinds of request are illegal: mode 2 with X, `ptr_sel` 3 in modes 1..4, and mode codes 5..7. An illegal request raises `mode_err` with `done` one cycle after acceptance. It raises no region select, no `oor` and no `wb_valid`.
- R10: Register-file, I/O and out-of-range accesses give `done` one cycle after acceptance. SRAM accesses give `done` two cycles after acceptance. In the cycle between, `busy` is high, `req_ready` is low, `ea` holds, and any request offered then has no effect.
- R11: While `rst_n` is low and after it is released, `done`, `busy`, `wb_valid`, `oor`, `mode_err` and all region selects are low until a request is accepted, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| mode | input | 3 | Addressing mode code (0..4 legal) |
| ptr_sel | input | 2 | Pointer choice: 0 X, 1 Y, 2 Z |
| disp | input | 6 | Unsigned displacement |
| direct_addr | input | 16 | Address for direct mode |
| ptr_x | input | 16 | X pair, low byte from the even register |
| ptr_y | input | 16 | Y pair, low byte from the even register |
| ptr_z | input | 16 | Z pair, low byte from the even register |
| ea | output | 16 | Effective address of the current access |
| sel_rf | output | 1 | Register-file region enable |
| sel_io | output | 1 | I/O region enable |
| sel_sram | output | 1 | SRAM region enable |
| oor | output | 1 | Address outside the mapped space (with done) |
| mode_err | output | 1 | Illegal request (with done) |
| wb_valid | output | 1 | Pointer write-back strobe (with done) |
| wb_ptr | output | 2 | Pointer code to update |
| wb_data | output | 16 | New pointer value |
| busy | output | 1 | Multi-cycle access in progress |
| done | output | 1 | Access completes this cycle |

## Verification
The effective address and the region select are registered, so both are due in the first cycle after the accepting edge. `done`, `oor`, `mode_err` and the write-back are due in that same cycle for one-cycle accesses, and one cycle later for SRAM. The bench drives each request at a falling edge and lets one rising edge accept it. It checks the address and select at the next falling edge. For an SRAM access it also checks `busy` high and `done` low at that falling edge, then checks completion one falling edge later. To show that a request offered while busy is ignored, the bench watches for an extra `done` or a changed `ea` in the cycles that follow.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_DIRECT  = 3'd0,
    AM_IND     = 3'd1,
    AM_DISP    = 3'd2,
    AM_PREDEC  = 3'd3,
    AM_POSTINC = 3'd4
  } amode_e;

  typedef enum logic [1:0] {
    PS_X   = 2'd0,
    PS_Y   = 2'd1,
    PS_Z   = 2'd2,
    PS_BAD = 2'd3
  } psel_e;

  typedef enum logic [1:0] {
    RG_RF   = 2'd0,
    RG_IO   = 2'd1,
    RG_SRAM = 2'd2,
    RG_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DISP_W = 6
) (
  input  logic [2:0]        mode,
  input  logic [1:0]        psel,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     direct_addr,
  input  logic [AW-1:0]     px,
  input  logic [AW-1:0]     py,
  input  logic [AW-1:0]     pz,
  output logic [AW-1:0]     ea,
  output logic              wb_en,
  output logic [AW-1:0]     wb_data,
  output logic              illegal
);
  logic [AW-1:0] base, base_dec, base_inc;
  logic          ptr_ok;

  always_comb begin
    case (psel_e'(psel))
      PS_X:    base = px;
      PS_Y:    base = py;
      default: base = pz;
    endcase
    ptr_ok   = (psel_e'(psel) != PS_BAD);
    base_dec = base - AW'(1);
    base_inc = base + AW'(1);
  end

  always_comb begin
    ea      = '0;
    wb_en   = 1'b0;
    wb_data = base;
    illegal = 1'b0;
    case (amode_e'(mode))
      AM_DIRECT: ea = direct_addr;
      AM_IND: begin
        if (ptr_ok) ea = base;
        else        illegal = 1'b1;
      end
      AM_DISP: begin
        if (ptr_ok && psel_e'(psel) != PS_X) ea = base + AW'(disp);
        else                                  illegal = 1'b1;
      end
      AM_PREDEC: begin
        if (ptr_ok) begin
          ea      = base_dec;
          wb_en   = 1'b1;
          wb_data = base_dec;
        end else begin
          illegal = 1'b1;
        end
      end
      AM_POSTINC: begin
        if (ptr_ok) begin
          ea      = base;
          wb_en   = 1'b1;
          wb_data = base_inc;
        end else begin
          illegal = 1'b1;
        end
      end
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/agu_region_dec.sv
module agu_region_dec
  import agu_pkg::*;
#(
  parameter int AW     = 16,
  parameter int RF_N   = 32,
  parameter int IO_N   = 64,
  parameter int SRAM_N = 128
) (
  input  logic [AW-1:0] addr,
  output region_e       region
);
  localparam logic [AW-1:0] IO_BASE   = AW'(RF_N);
  localparam logic [AW-1:0] SRAM_BASE = AW'(RF_N + IO_N);
  localparam logic [AW-1:0] MAP_END   = AW'(RF_N + IO_N + SRAM_N);

  always_comb begin
    if (addr < IO_BASE)        region = RG_RF;
    else if (addr < SRAM_BASE) region = RG_IO;
    else if (addr < MAP_END)   region = RG_SRAM;
    else                       region = RG_NONE;
  end
endmodule

// File: rtl/agu_access_ctl.sv
module agu_access_ctl #(
  parameter int SLOW_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic slow,
  output logic active,
  output logic busy,
  output logic done
);
  localparam int CW = (SLOW_LAT > 1) ? $clog2(SLOW_LAT) : 1;
  localparam logic [CW-1:0] SLOW_LOAD = CW'(SLOW_LAT - 1);

  logic          act_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (accept) begin
      act_q <= 1'b1;
      cnt_q <= slow ? SLOW_LOAD : '0;
    end else if (act_q && cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end else begin
      act_q <= 1'b0;
    end
  end

  assign active = act_q;
  assign busy   = act_q && (cnt_q != '0);
  assign done   = act_q && (cnt_q == '0);
endmodule

// File: rtl/dspace_agu.sv
module dspace_agu
  import agu_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DISP_W   = 6,
  parameter int RF_N     = 32,
  parameter int IO_N     = 64,
  parameter int SRAM_N   = 128,
  parameter int SRAM_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        mode,
  input  logic [1:0]        ptr_sel,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     direct_addr,
  input  logic [AW-1:0]     ptr_x,
  input  logic [AW-1:0]     ptr_y,
  input  logic [AW-1:0]     ptr_z,
  output logic [AW-1:0]     ea,
  output logic              sel_rf,
  output logic              sel_io,
  output logic              sel_sram,
  output logic              oor,
  output logic              mode_err,
  output logic              wb_valid,
  output logic [1:0]        wb_ptr,
  output logic [AW-1:0]     wb_data,
  output logic              busy,
  output logic              done
);
  logic [AW-1:0] ea_c, wbd_c;
  logic          wb_en_c, illegal_c, accept, active;
  region_e       region_c;

  logic [AW-1:0] ea_q, wbd_q;
  logic [1:0]    wbp_q;
  logic          err_q, wb_en_q;
  region_e       rg_q;

  agu_addr_calc #(.AW(AW), .DISP_W(DISP_W)) u_calc (
    .mode(mode), .psel(ptr_sel), .disp(disp), .direct_addr(direct_addr),
    .px(ptr_x), .py(ptr_y), .pz(ptr_z),
    .ea(ea_c), .wb_en(wb_en_c), .wb_data(wbd_c), .illegal(illegal_c)
  );

  agu_region_dec #(.AW(AW), .RF_N(RF_N), .IO_N(IO_N), .SRAM_N(SRAM_N)) u_dec (
    .addr(ea_c), .region(region_c)
  );

  agu_access_ctl #(.SLOW_LAT(SRAM_LAT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .slow(region_c == RG_SRAM && !illegal_c),
    .active(active), .busy(busy), .done(done)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_q    <= '0;
      wbd_q   <= '0;
      wbp_q   <= '0;
      err_q   <= 1'b0;
      wb_en_q <= 1'b0;
      rg_q    <= RG_NONE;
    end else if (accept) begin
      ea_q    <= ea_c;
      wbd_q   <= wbd_c;
      wbp_q   <= ptr_sel;
      err_q   <= illegal_c;
      wb_en_q <= wb_en_c && !illegal_c;
      rg_q    <= illegal_c ? RG_NONE : region_c;
    end
  end

  assign ea       = ea_q;
  assign sel_rf   = active && rg_q == RG_RF;
  assign sel_io   = active && rg_q == RG_IO;
  assign sel_sram = active && rg_q == RG_SRAM;
  assign oor      = done && rg_q == RG_NONE && !err_q;
  assign mode_err = done && err_q;
  assign wb_valid = done && wb_en_q;
  assign wb_ptr   = wbp_q;
  assign wb_data  = wbd_q;
endmodule

// File: rtl/dspace_agu_chk.sv
module dspace_agu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  mode,
  input logic [15:0] direct_addr,
  input logic [15:0] ea,
  input logic        sel_rf,
  input logic        sel_io,
  input logic        sel_sram,
  input logic        oor,
  input logic        mode_err,
  input logic        wb_valid,
  input logic        busy,
  input logic        done
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_rf, sel_io, sel_sram})); // R1
  AST_OOR_NO_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    oor |-> !(sel_rf || sel_io || sel_sram)); // R3
  AST_OOR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    oor |-> $past(req_valid && req_ready)); // R3
  AST_DIRECT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && mode == 3'd0) |=> !wb_valid); // R4
  AST_WB_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !(wb_valid || oor || sel_rf || sel_io || sel_sram)); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && !req_ready)); // R10
  AST_EA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ea)); // R10
  AST_FAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && mode == 3'd0 && direct_addr < 16'h0060) |=> done); // R10
endmodule

bind dspace_agu dspace_agu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mode(mode), .direct_addr(direct_addr), .ea(ea),
  .sel_rf(sel_rf), .sel_io(sel_io), .sel_sram(sel_sram),
  .oor(oor), .mode_err(mode_err), .wb_valid(wb_valid),
  .busy(busy), .done(done)
);

// File: tb/tb_dspace_agu.sv
module tb_dspace_agu;
  typedef struct packed {
    logic [2:0]  mode;
    logic [1:0]  psel;
    logic [5:0]  disp;
    logic [15:0] dir;
    logic [15:0] x;
    logic [15:0] y;
    logic [15:0] z;
    logic [15:0] exp_ea;
    logic [1:0]  exp_rg;   // 0 rf, 1 io, 2 sram, 3 none
    logic        exp_err;
    logic        exp_wb;
    logic [15:0] exp_wbd;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd0, 6'd0,  16'h0005, 16'h0010, 16'h0040, 16'h00D0, 16'h0005, 2'd0, 1'b0, 1'b0, 16'h0000}, // R4 R1
    '{3'd0, 2'd1, 6'd0,  16'h001F, 16'h0010, 16'h0040, 16'h00D0, 16'h001F, 2'd0, 1'b0, 1'b0, 16'h0000}, // R1
    '{3'd0, 2'd2, 6'd0,  16'h0020, 16'h0010, 16'h0040, 16'h00D0, 16'h0020, 2'd1, 1'b0, 1'b0, 16'h0000}, // R2
    '{3'd0, 2'd3, 6'd0,  16'h005F, 16'h0010, 16'h0040, 16'h00D0, 16'h005F, 2'd1, 1'b0, 1'b0, 16'h0000}, // R2
    '{3'd0, 2'd0, 6'd0,  16'h0060, 16'h0010, 16'h0040, 16'h00D0, 16'h0060, 2'd2, 1'b0, 1'b0, 16'h0000}, // R2
    '{3'd0, 2'd0, 6'd0,  16'h00DF, 16'h0010, 16'h0040, 16'h00D0, 16'h00DF, 2'd2, 1'b0, 1'b0, 16'h0000}, // R2
    '{3'd0, 2'd0, 6'd0,  16'h00E0, 16'h0010, 16'h0040, 16'h00D0, 16'h00E0, 2'd3, 1'b0, 1'b0, 16'h0000}, // R3
    '{3'd0, 2'd0, 6'd0,  16'hFFFF, 16'h0010, 16'h0040, 16'h00D0, 16'hFFFF, 2'd3, 1'b0, 1'b0, 16'h0000}, // R3
    '{3'd1, 2'd0, 6'd0,  16'h00C0, 16'h0010, 16'h0040, 16'h00D0, 16'h0010, 2'd0, 1'b0, 1'b0, 16'h0000}, // R5
    '{3'd1, 2'd2, 6'd0,  16'h0000, 16'h0010, 16'h0040, 16'h00D0, 16'h00D0, 2'd2, 1'b0, 1'b0, 16'h0000}, // R5
    '{3'd1, 2'd1, 6'd0,  16'h0000, 16'h0010, 16'h0040, 16'h00D0, 16'h0040, 2'd1, 1'b0, 1'b0, 16'h0000}, // R5
    '{3'd2, 2'd1, 6'd63, 16'h0000, 16'h0010, 16'h0040, 16'h00D0, 16'h007F, 2'd2, 1'b0, 1'b0, 16'h0000}, // R6
    '{3'd2, 2'd2, 6'd15, 16'h0000, 16'h0010, 16'h0040, 16'h00D0, 16'h00DF, 2'd2, 1'b0, 1'b0, 16'h0000}, // R6
    '{3'd2, 2'd2, 6'd16, 16'h0000, 16'h0010, 16'h0040, 16'h00D0, 16'h00E0, 2'd3, 1'b0, 1'b0, 16'h0000}, // R6
    '{3'd2, 2'd0, 6'd5,  16'h0000, 16'h0010, 16'h0040, 16'h00D0, 16'h0000, 2'd3, 1'b1, 1'b0, 16'h0000}, // R9
    '{3'd3, 2'd1, 6'd0,  16'h0000, 16'h0010, 16'h0040, 16'h00D0, 16'h003F, 2'd1, 1'b0, 1'b1, 16'h003F}, // R7
    '{3'd3, 2'd0, 6'd0,  16'h0000, 16'h0000, 16'h0040, 16'h00D0, 16'hFFFF, 2'd3, 1'b0, 1'b1, 16'hFFFF}, // R7
    '{3'd4, 2'd2, 6'd0,  16'h0000, 16'h0010, 16'h0040, 16'h00D0, 16'h00D0, 2'd2, 1'b0, 1'b1, 16'h00D1}, // R8
    '{3'd4, 2'd1, 6'd0,  16'h0000, 16'h0010, 16'hFFFF, 16'h00D0, 16'hFFFF, 2'd3, 1'b0, 1'b1, 16'h0000}, // R8
    '{3'd5, 2'd1, 6'd0,  16'h0005, 16'h0010, 16'h0040, 16'h00D0, 16'h0000, 2'd3, 1'b1, 1'b0, 16'h0000}, // R9
    '{3'd1, 2'd3, 6'd0,  16'h0000, 16'h0010, 16'h0040, 16'h00D0, 16'h0000, 2'd3, 1'b1, 1'b0, 16'h0000}, // R9
    '{3'd3, 2'd3, 6'd0,  16'h0000, 16'h0010, 16'h0040, 16'h00D0, 16'h0000, 2'd3, 1'b1, 1'b0, 16'h0000}, // R9
    '{3'd2, 2'd1, 6'd0,  16'h0000, 16'h0010, 16'h0040, 16'h00D0, 16'h0040, 2'd1, 1'b0, 1'b0, 16'h0000}  // R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  ptr_sel = '0;
  logic [5:0]  disp = '0;
  logic [15:0] direct_addr = '0;
  logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
  logic        req_ready, sel_rf, sel_io, sel_sram, oor, mode_err, wb_valid, busy, done;
  logic [15:0] ea, wb_data;
  logic [1:0]  wb_ptr;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dspace_agu dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mode(mode), .ptr_sel(ptr_sel), .disp(disp), .direct_addr(direct_addr),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z), .ea(ea),
    .sel_rf(sel_rf), .sel_io(sel_io), .sel_sram(sel_sram), .oor(oor),
    .mode_err(mode_err), .wb_valid(wb_valid), .wb_ptr(wb_ptr), .wb_data(wb_data),
    .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.exp_err)          return "R9";
    if (v.mode == 3'd3)     return "R7";
    if (v.mode == 3'd4)     return "R8";
    if (v.mode == 3'd2)     return "R6";
    if (v.mode == 3'd1)     return "R5";
    if (v.exp_rg == 2'd3)   return "R3";
    if (v.exp_rg == 2'd0)   return "R1";
    return "R2";
  endfunction

  task automatic run_vec(input vec_t v);
    string t;
    t = tag_of(v);
    @(negedge clk);
    mode = v.mode; ptr_sel = v.psel; disp = v.disp; direct_addr = v.dir;
    ptr_x = v.x; ptr_y = v.y; ptr_z = v.z; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!v.exp_err) check({t, " ea"}, 32'(ea), 32'(v.exp_ea));
    check({t, " sel"}, 32'({sel_rf, sel_io, sel_sram}),
          32'((v.exp_rg == 2'd0) ? 3'b100 : (v.exp_rg == 2'd1) ? 3'b010 :
              (v.exp_rg == 2'd2) ? 3'b001 : 3'b000));
    if (v.exp_rg == 2'd2 && !v.exp_err) begin
      check("R10 sram busy/ready/done", 32'({busy, req_ready, done}), 32'(3'b100));
      @(negedge clk);
    end
    check({t, " done"}, 32'(done), 32'(1));
    check({t, " oor"}, 32'(oor), 32'(v.exp_rg == 2'd3 && !v.exp_err));
    check({t, " err"}, 32'(mode_err), 32'(v.exp_err));
    check({t, " wb_valid"}, 32'(wb_valid), 32'(v.exp_wb));
    if (v.exp_wb) begin
      check({t, " wb_data"}, 32'(wb_data), 32'(v.exp_wbd));
      check({t, " wb_ptr"}, 32'(wb_ptr), 32'(v.psel));
    end
  endtask

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11 reset outputs", 32'({done, busy, wb_valid, oor, mode_err, sel_rf, sel_io, sel_sram}), 32'(0));
    check("R11 reset ready", 32'(req_ready), 32'(1));
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", 32'({done, busy, sel_rf, sel_io, sel_sram}), 32'(0));

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R10: request while busy is ignored
    @(negedge clk);
    mode = 3'd0; direct_addr = 16'h0080; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    direct_addr = 16'h0005;   // offered during the busy cycle
    check("R10 ready low while busy", 32'(req_ready), 32'(0));
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 sram done at second cycle", 32'(done), 32'(1));
    check("R10 ea unchanged by ignored request", 32'(ea), 32'(16'h0080));
    check("R10 select kept", 32'({sel_rf, sel_sram}), 32'(2'b01));
    @(negedge clk);
    check("R10 no extra access", 32'({done, sel_rf}), 32'(0));

    // R10: back-to-back one-cycle accesses, new request taken in done cycle
    mode = 3'd0; direct_addr = 16'h0030; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    direct_addr = 16'h0002;
    check("R10 io done first", 32'({done, sel_io}), 32'(2'b11));
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 back-to-back ea", 32'(ea), 32'(16'h0002));
    check("R1 back-to-back rf sel", 32'({done, sel_rf}), 32'(2'b11));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule